// File: doc/BRIEF.md
# Reservation Station Dataflow Scheduler

This block is the waiting room between register renaming and execution. Renamed micro-ops enter it up to three per cycle. Each one carries a target unit type and a pair of source operands. An operand whose value is already known (a literal, a committed register, or a finished reorder-buffer result) is stored with its value. An operand still being computed is stored as a tag, and the entry watches the result broadcast lanes for that tag.

Once every source of an entry holds a value, the entry competes for the dispatch port of its unit type. The three ports are integer, floating point and address generation. Memory micro-ops go to the address generation port. Each port, when its unit is not busy, sends out the oldest ready entry that targets it. Dispatch therefore follows data readiness, not program order. A flush empties the whole window in one cycle.

Top module: `rs_sched`

## Requirements
- R1: After reset the window is empty: no port dispatches, and an offer of three micro-ops is accepted (`alloc_ready` high).
- R2: A source of kind 0 (literal), 1 (committed register) or 2 (reorder-buffer value) is stored with the value given on allocation. An entry whose sources are all of these kinds can dispatch in the cycle after allocation.
- R3: A source of kind 3 (pending) waits for its tag. When a valid broadcast lane carries that tag, the lane's data is captured, and the entry can dispatch from the following cycle.
- R4: A pending source whose tag is on a broadcast lane in its allocation cycle captures that data at once (bypass). The entry can dispatch in the next cycle.
- R5: Unit code 0 goes to port 0 (integer), code 1 to port 1 (floating point), and code 2 to port 2 (address generation, used by memory ops). Code 3 is reserved. Source 0 occupies the low `DATA_W` bits of a port's operand field.
- R6: When several ready entries target one port, the entry allocated earliest wins. Within one allocation cycle, a lower slot index counts as older.
- R7: While a port's busy input is high, that port dispatches nothing, and its ready entries stay in the window.
- R8: A younger ready entry dispatches ahead of an older entry that is still waiting for an operand.
- R9: An offer is accepted whole, and only when the number of free entries (counted before this cycle's dispatches) is at least the number of valid slots. Otherwise nothing is taken.
- R10: A flush empties every entry by the next cycle. It blocks dispatch in its own cycle and discards any offer made in that cycle.
- R11: Each port dispatches at most one entry per cycle. A dispatched entry leaves the window and is free again from the next cycle.
- R12: The window holds 20 entries. When all of them are occupied, any offer is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Empty the window |
| alloc_valid | input | ALLOC_W | One bit per offered slot |
| alloc_ready | output | 1 | The offer in this cycle is taken |
| alloc_unit | input | 2*ALLOC_W | Unit code per slot |
| alloc_dest | input | TAG_W*ALLOC_W | Result tag per slot |
| alloc_src_kind | input | 2*NSRC*ALLOC_W | Operand origin code per source |
| alloc_src_tag | input | TAG_W*NSRC*ALLOC_W | Tag awaited by a pending source |
| alloc_src_data | input | DATA_W*NSRC*ALLOC_W | Value of a source that is known |
| bc_valid | input | NBC | Broadcast lane valid |
| bc_tag | input | TAG_W*NBC | Broadcast result tag |
| bc_data | input | DATA_W*NBC | Broadcast result value |
| port_busy | input | 3 | Execution unit of each port cannot take work |
| disp_valid | output | 3 | Port issues a micro-op this cycle |
| disp_dest | output | TAG_W*3 | Result tag of the issued micro-op |
| disp_data | output | DATA_W*NSRC*3 | Operand values of the issued micro-op |

## Verification
The bench first feeds three micro-ops whose operands are all known, one per unit type. This shows that the origins are routed and that the ports are kept apart. Next come pending operands woken by a later broadcast, and pending operands that meet their broadcast in the allocation cycle. Together these separate delayed capture from bypass capture. A burst of same-port ready entries, and a younger ready op placed behind an older waiting one, test oldest-first selection against dataflow order. The window is then filled to its limit with ops that cannot wake, which exposes the all-or-nothing allocation rule, and a final flush is raised over a ready entry while an offer is pending.

// File: rtl/rs_pkg.sv
package rs_pkg;
   localparam int UNIT_W  = 2;
   localparam int KIND_W  = 2;
   localparam int NPORT   = 3;

   typedef enum logic [KIND_W-1:0] {
      SRC_LIT  = 2'd0,
      SRC_REG  = 2'd1,
      SRC_ROB  = 2'd2,
      SRC_WAIT = 2'd3
   } src_kind_e;

   typedef enum logic [UNIT_W-1:0] {
      UNIT_INT = 2'd0,
      UNIT_FP  = 2'd1,
      UNIT_AGU = 2'd2,
      UNIT_RSV = 2'd3
   } unit_e;
endpackage

// File: rtl/rs_entry.sv
module rs_entry
   import rs_pkg::*;
#(
   parameter int NSRC   = 2,
   parameter int TAG_W  = 6,
   parameter int DATA_W = 16,
   parameter int NBC    = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     flush,
   input  logic                     wr_en,
   input  logic                     clr,
   input  logic [UNIT_W-1:0]        wr_unit,
   input  logic [TAG_W-1:0]         wr_dest,
   input  logic [NSRC*KIND_W-1:0]   wr_kind,
   input  logic [NSRC*TAG_W-1:0]    wr_tag,
   input  logic [NSRC*DATA_W-1:0]   wr_data,
   input  logic [NBC-1:0]           bc_valid,
   input  logic [NBC*TAG_W-1:0]     bc_tag,
   input  logic [NBC*DATA_W-1:0]    bc_data,
   output logic                     valid,
   output logic                     rdy,
   output logic [UNIT_W-1:0]        unit,
   output logic [TAG_W-1:0]         dest,
   output logic [NSRC*DATA_W-1:0]   opnd
);
   logic [NSRC-1:0] src_rdy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      valid <= 1'b0;
      else if (flush)  valid <= 1'b0;
      else if (wr_en)  valid <= 1'b1;
      else if (clr)    valid <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         unit <= '0;
         dest <= '0;
      end else if (wr_en) begin
         unit <= wr_unit;
         dest <= wr_dest;
      end
   end

   generate
      for (genvar s = 0; s < NSRC; s++) begin : g_src
         logic [TAG_W-1:0]  tag_q;
         logic [TAG_W-1:0]  cmp_tag;
         logic              hit;
         logic [DATA_W-1:0] hit_data;
         logic              wr_pend;

         assign wr_pend = (wr_kind[s*KIND_W +: KIND_W] == SRC_WAIT);
         assign cmp_tag = wr_en ? wr_tag[s*TAG_W +: TAG_W] : tag_q;

         always_comb begin
            hit      = 1'b0;
            hit_data = '0;
            for (int c = 0; c < NBC; c++) begin
               if (bc_valid[c] && bc_tag[c*TAG_W +: TAG_W] == cmp_tag) begin
                  hit      = 1'b1;
                  hit_data = bc_data[c*DATA_W +: DATA_W];
               end
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tag_q                       <= '0;
               src_rdy[s]                  <= 1'b0;
               opnd[s*DATA_W +: DATA_W]    <= '0;
            end else if (wr_en) begin
               tag_q <= wr_tag[s*TAG_W +: TAG_W];
               if (wr_pend) begin
                  src_rdy[s]               <= hit;
                  opnd[s*DATA_W +: DATA_W] <= hit_data;
               end else begin
                  src_rdy[s]               <= 1'b1;
                  opnd[s*DATA_W +: DATA_W] <= wr_data[s*DATA_W +: DATA_W];
               end
            end else if (valid && !src_rdy[s] && hit) begin
               src_rdy[s]                  <= 1'b1;
               opnd[s*DATA_W +: DATA_W]    <= hit_data;
            end
         end
      end
   endgenerate

   assign rdy = &src_rdy;
endmodule

// File: rtl/rs_alloc_pick.sv
module rs_alloc_pick #(
   parameter int ENTRIES = 20,
   parameter int ALLOC_W = 3,
   parameter int SLOT_W  = 2
) (
   input  logic [ENTRIES-1:0]        ent_valid,
   input  logic [ALLOC_W-1:0]        offer,
   output logic                      room,
   output logic [ENTRIES-1:0]        take,
   output logic [ENTRIES*SLOT_W-1:0] take_slot
);
   localparam int CNT_W = $clog2(ENTRIES + 1);

   logic [CNT_W-1:0] n_free;
   logic [CNT_W-1:0] n_need;

   always_comb begin
      n_free = '0;
      for (int e = 0; e < ENTRIES; e++) n_free = n_free + CNT_W'(!ent_valid[e]);
      n_need = '0;
      for (int s = 0; s < ALLOC_W; s++) n_need = n_need + CNT_W'(offer[s]);
   end

   assign room = (n_free >= n_need);

   always_comb begin
      logic [ALLOC_W-1:0] left;
      logic               found;
      left      = offer;
      take      = '0;
      take_slot = '0;
      for (int e = 0; e < ENTRIES; e++) begin
         found = 1'b0;
         if (!ent_valid[e]) begin
            for (int s = 0; s < ALLOC_W; s++) begin
               if (left[s] && !found) begin
                  found                        = 1'b1;
                  left[s]                      = 1'b0;
                  take[e]                      = 1'b1;
                  take_slot[e*SLOT_W +: SLOT_W] = SLOT_W'(s);
               end
            end
         end
      end
   end
endmodule

// File: rtl/rs_oldest_pick.sv
module rs_oldest_pick #(
   parameter int ENTRIES = 20
) (
   input  logic [ENTRIES-1:0]         req,
   input  logic [ENTRIES*ENTRIES-1:0] older,
   output logic [ENTRIES-1:0]         gnt,
   output logic                       any
);
   generate
      for (genvar i = 0; i < ENTRIES; i++) begin : g_cand
         logic [ENTRIES-1:0] beaten_by;
         for (genvar j = 0; j < ENTRIES; j++) begin : g_cmp
            assign beaten_by[j] = req[j] & older[j*ENTRIES + i];
         end
         assign gnt[i] = req[i] & ~(|beaten_by);
      end
   endgenerate

   assign any = |req;
endmodule

// File: rtl/rs_sched.sv
module rs_sched
   import rs_pkg::*;
#(
   parameter int ENTRIES = 20,
   parameter int ALLOC_W = 3,
   parameter int NSRC    = 2,
   parameter int TAG_W   = 6,
   parameter int DATA_W  = 16,
   parameter int NBC     = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              flush,
   input  logic [ALLOC_W-1:0]                alloc_valid,
   output logic                              alloc_ready,
   input  logic [ALLOC_W*UNIT_W-1:0]         alloc_unit,
   input  logic [ALLOC_W*TAG_W-1:0]          alloc_dest,
   input  logic [ALLOC_W*NSRC*KIND_W-1:0]    alloc_src_kind,
   input  logic [ALLOC_W*NSRC*TAG_W-1:0]     alloc_src_tag,
   input  logic [ALLOC_W*NSRC*DATA_W-1:0]    alloc_src_data,
   input  logic [NBC-1:0]                    bc_valid,
   input  logic [NBC*TAG_W-1:0]              bc_tag,
   input  logic [NBC*DATA_W-1:0]             bc_data,
   input  logic [NPORT-1:0]                  port_busy,
   output logic [NPORT-1:0]                  disp_valid,
   output logic [NPORT*TAG_W-1:0]            disp_dest,
   output logic [NPORT*NSRC*DATA_W-1:0]      disp_data
);
   localparam int SLOT_W = (ALLOC_W > 1) ? $clog2(ALLOC_W) : 1;
   localparam int OPND_W = NSRC * DATA_W;

   generate
      if (ALLOC_W < 1 || ALLOC_W > ENTRIES || NSRC < 1 || NBC < 1 ||
          TAG_W < 1 || DATA_W < 1) begin : g_bad_cfg
         $error("rs_sched: parameter set out of range");
      end
   endgenerate

   logic [ENTRIES-1:0]        ent_valid;
   logic [ENTRIES-1:0]        ent_rdy;
   logic [UNIT_W-1:0]         ent_unit [ENTRIES];
   logic [TAG_W-1:0]          ent_dest [ENTRIES];
   logic [OPND_W-1:0]         ent_opnd [ENTRIES];
   logic [ENTRIES-1:0]        take;
   logic [ENTRIES*SLOT_W-1:0] take_slot;
   logic [ENTRIES-1:0]        wr_en;
   logic [ENTRIES-1:0]        clr;
   logic                      alloc_fire;
   logic [ENTRIES-1:0]        older_q [ENTRIES];
   logic [ENTRIES*ENTRIES-1:0] older_flat;
   logic [NPORT*ENTRIES-1:0]  gnt;

   rs_alloc_pick #(.ENTRIES(ENTRIES), .ALLOC_W(ALLOC_W), .SLOT_W(SLOT_W)) u_pick (
      .ent_valid (ent_valid),
      .offer     (alloc_valid),
      .room      (alloc_ready),
      .take      (take),
      .take_slot (take_slot)
   );

   assign alloc_fire = alloc_ready & ~flush & (|alloc_valid);
   assign wr_en      = take & {ENTRIES{alloc_fire}};

   generate
      for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
         logic [SLOT_W-1:0] sl;
         int                si;
         assign sl = take_slot[e*SLOT_W +: SLOT_W];
         assign si = int'(sl);

         rs_entry #(.NSRC(NSRC), .TAG_W(TAG_W), .DATA_W(DATA_W), .NBC(NBC)) u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .flush    (flush),
            .wr_en    (wr_en[e]),
            .clr      (clr[e]),
            .wr_unit  (alloc_unit[si*UNIT_W +: UNIT_W]),
            .wr_dest  (alloc_dest[si*TAG_W +: TAG_W]),
            .wr_kind  (alloc_src_kind[si*NSRC*KIND_W +: NSRC*KIND_W]),
            .wr_tag   (alloc_src_tag[si*NSRC*TAG_W +: NSRC*TAG_W]),
            .wr_data  (alloc_src_data[si*OPND_W +: OPND_W]),
            .bc_valid (bc_valid),
            .bc_tag   (bc_tag),
            .bc_data  (bc_data),
            .valid    (ent_valid[e]),
            .rdy      (ent_rdy[e]),
            .unit     (ent_unit[e]),
            .dest     (ent_dest[e]),
            .opnd     (ent_opnd[e])
         );

         assign older_flat[e*ENTRIES +: ENTRIES] = older_q[e];
      end
   endgenerate

   // age matrix: older_q[i][j] set when entry i was allocated before entry j
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) older_q[i] <= '0;
      end else if (!flush) begin
         for (int i = 0; i < ENTRIES; i++) begin
            for (int j = 0; j < ENTRIES; j++) begin
               if (wr_en[i])
                  older_q[i][j] <= wr_en[j] &&
                     (take_slot[i*SLOT_W +: SLOT_W] < take_slot[j*SLOT_W +: SLOT_W]);
               else if (wr_en[j])
                  older_q[i][j] <= 1'b1;
            end
         end
      end
   end

   generate
      for (genvar p = 0; p < NPORT; p++) begin : g_port
         logic [ENTRIES-1:0] req;
         logic               any;
         for (genvar e = 0; e < ENTRIES; e++) begin : g_req
            assign req[e] = ent_valid[e] & ent_rdy[e] & (ent_unit[e] == UNIT_W'(p));
         end
         rs_oldest_pick #(.ENTRIES(ENTRIES)) u_sel (
            .req   (req),
            .older (older_flat),
            .gnt   (gnt[p*ENTRIES +: ENTRIES]),
            .any   (any)
         );
         assign disp_valid[p] = any & ~port_busy[p] & ~flush;
      end
   endgenerate

   always_comb begin
      clr       = '0;
      disp_dest = '0;
      disp_data = '0;
      for (int p = 0; p < NPORT; p++) begin
         for (int e = 0; e < ENTRIES; e++) begin
            if (gnt[p*ENTRIES + e]) begin
               clr[e] = clr[e] | disp_valid[p];
               disp_dest[p*TAG_W +: TAG_W]   = disp_dest[p*TAG_W +: TAG_W] | ent_dest[e];
               disp_data[p*OPND_W +: OPND_W] = disp_data[p*OPND_W +: OPND_W] | ent_opnd[e];
            end
         end
      end
   end
endmodule

// File: rtl/rs_sched_chk.sv
module rs_sched_chk #(
   parameter int ENTRIES = 20,
   parameter int ALLOC_W = 3,
   parameter int NPORT   = 3
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     flush,
   input logic [ALLOC_W-1:0]       alloc_valid,
   input logic                     alloc_ready,
   input logic [NPORT-1:0]         port_busy,
   input logic [NPORT-1:0]         disp_valid,
   input logic [ENTRIES-1:0]       ent_valid,
   input logic [NPORT*ENTRIES-1:0] gnt
);
   int occ;
   int n_in;
   int n_out;

   always_comb begin
      occ   = $countones(ent_valid);
      n_in  = (alloc_ready && !flush) ? $countones(alloc_valid) : 0;
      n_out = $countones(disp_valid);
   end

   // R10
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (ent_valid == '0));

   // R9
   occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flush |=> (occ == $past(occ) + $past(n_in) - $past(n_out)));

   // R12
   full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == ENTRIES && alloc_valid != '0) |-> !alloc_ready);

   generate
      for (genvar p = 0; p < NPORT; p++) begin : g_pc
         // R7
         busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            port_busy[p] |-> !disp_valid[p]);
         // R11
         grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(gnt[p*ENTRIES +: ENTRIES]));
      end
   endgenerate
endmodule

bind rs_sched rs_sched_chk #(.ENTRIES(ENTRIES), .ALLOC_W(ALLOC_W), .NPORT(rs_pkg::NPORT)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .flush       (flush),
   .alloc_valid (alloc_valid),
   .alloc_ready (alloc_ready),
   .port_busy   (port_busy),
   .disp_valid  (disp_valid),
   .ent_valid   (ent_valid),
   .gnt         (gnt)
);

// File: tb/rs_sched_bench.sv
`timescale 1ns/1ps
module rs_sched_bench;
   localparam int ENTRIES = 20;
   localparam int ALLOC_W = 3;
   localparam int NSRC    = 2;
   localparam int TAG_W   = 6;
   localparam int DATA_W  = 16;
   localparam int NBC     = 2;
   localparam int NP      = 3;
   localparam int OPW     = NSRC * DATA_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic flush;
   logic [ALLOC_W-1:0]           alloc_valid;
   logic                         alloc_ready;
   logic [ALLOC_W*2-1:0]         alloc_unit;
   logic [ALLOC_W*TAG_W-1:0]     alloc_dest;
   logic [ALLOC_W*NSRC*2-1:0]    alloc_src_kind;
   logic [ALLOC_W*NSRC*TAG_W-1:0] alloc_src_tag;
   logic [ALLOC_W*OPW-1:0]       alloc_src_data;
   logic [NBC-1:0]               bc_valid;
   logic [NBC*TAG_W-1:0]         bc_tag;
   logic [NBC*DATA_W-1:0]        bc_data;
   logic [NP-1:0]                port_busy;
   logic [NP-1:0]                disp_valid;
   logic [NP*TAG_W-1:0]          disp_dest;
   logic [NP*OPW-1:0]            disp_data;

   always #2.5 clk = ~clk;

   rs_sched #(.ENTRIES(ENTRIES), .ALLOC_W(ALLOC_W), .NSRC(NSRC), .TAG_W(TAG_W),
              .DATA_W(DATA_W), .NBC(NBC)) u_rs_sched (.*);

   int nchk = 0;
   int nfail = 0;
   bit done = 0;
   string cur_req = "R1";

   // reference model: unordered pool with allocation sequence numbers
   bit m_v [ENTRIES];
   int m_unit [ENTRIES];
   int m_dest [ENTRIES];
   int m_seq [ENTRIES];
   bit m_rdy [ENTRIES][NSRC];
   int m_tag [ENTRIES][NSRC];
   int m_dat [ENTRIES][NSRC];
   int seq_ctr = 0;
   int win [NP];
   bit exp_go [NP];
   bit exp_room;

   task automatic chk(bit ok, string req, longint act, longint exp_v);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp_v, $time);
      end
   endtask

   task automatic clear_in();
      flush = 0; alloc_valid = '0; alloc_unit = '0; alloc_dest = '0;
      alloc_src_kind = '0; alloc_src_tag = '0; alloc_src_data = '0;
      bc_valid = '0; bc_tag = '0; bc_data = '0; port_busy = '0;
   endtask

   task automatic put(int s, int unit, int dest, int k0, int t0, int d0, int k1, int t1, int d1);
      alloc_valid[s] = 1'b1;
      alloc_unit[s*2 +: 2] = 2'(unit);
      alloc_dest[s*TAG_W +: TAG_W] = TAG_W'(dest);
      alloc_src_kind[(s*NSRC)*2 +: 2] = 2'(k0);
      alloc_src_kind[(s*NSRC+1)*2 +: 2] = 2'(k1);
      alloc_src_tag[(s*NSRC)*TAG_W +: TAG_W] = TAG_W'(t0);
      alloc_src_tag[(s*NSRC+1)*TAG_W +: TAG_W] = TAG_W'(t1);
      alloc_src_data[(s*NSRC)*DATA_W +: DATA_W] = DATA_W'(d0);
      alloc_src_data[(s*NSRC+1)*DATA_W +: DATA_W] = DATA_W'(d1);
   endtask

   task automatic bcast(int c, int tag, int data);
      bc_valid[c] = 1'b1;
      bc_tag[c*TAG_W +: TAG_W] = TAG_W'(tag);
      bc_data[c*DATA_W +: DATA_W] = DATA_W'(data);
   endtask

   task automatic compare();
      int nfree;
      int need;
      nfree = 0; need = 0;
      for (int e = 0; e < ENTRIES; e++) if (!m_v[e]) nfree++;
      for (int s = 0; s < ALLOC_W; s++) if (alloc_valid[s]) need++;
      exp_room = (nfree >= need);
      chk(alloc_ready == exp_room, "R9", alloc_ready, exp_room);
      for (int p = 0; p < NP; p++) begin
         win[p] = -1;
         for (int e = 0; e < ENTRIES; e++) begin
            if (m_v[e] && m_unit[e] == p && m_rdy[e][0] && m_rdy[e][1]) begin
               if (win[p] < 0 || m_seq[e] < m_seq[win[p]]) win[p] = e;
            end
         end
         exp_go[p] = (win[p] >= 0) && !port_busy[p] && !flush;
         chk(disp_valid[p] == exp_go[p], cur_req, disp_valid[p], exp_go[p]);
         if (exp_go[p]) begin
            chk(disp_dest[p*TAG_W +: TAG_W] == TAG_W'(m_dest[win[p]]), cur_req,
                disp_dest[p*TAG_W +: TAG_W], m_dest[win[p]]);
            chk(disp_data[p*OPW +: OPW] == {DATA_W'(m_dat[win[p]][1]), DATA_W'(m_dat[win[p]][0])},
                cur_req, disp_data[p*OPW +: OPW],
                {DATA_W'(m_dat[win[p]][1]), DATA_W'(m_dat[win[p]][0])});
         end
      end
   endtask

   task automatic update();
      if (flush) begin
         for (int e = 0; e < ENTRIES; e++) m_v[e] = 0;
         return;
      end
      for (int e = 0; e < ENTRIES; e++)
         for (int s = 0; s < NSRC; s++)
            for (int c = 0; c < NBC; c++)
               if (m_v[e] && !m_rdy[e][s] && bc_valid[c] && int'(bc_tag[c*TAG_W +: TAG_W]) == m_tag[e][s]) begin
                  m_rdy[e][s] = 1;
                  m_dat[e][s] = int'(bc_data[c*DATA_W +: DATA_W]);
               end
      for (int p = 0; p < NP; p++) if (exp_go[p]) m_v[win[p]] = 0;
      if (exp_room) begin
         for (int s = 0; s < ALLOC_W; s++) begin
            if (alloc_valid[s]) begin
               int f;
               f = -1;
               for (int e = 0; e < ENTRIES; e++) if (!m_v[e] && f < 0) f = e;
               m_v[f] = 1;
               m_unit[f] = int'(alloc_unit[s*2 +: 2]);
               m_dest[f] = int'(alloc_dest[s*TAG_W +: TAG_W]);
               m_seq[f] = seq_ctr++;
               for (int k = 0; k < NSRC; k++) begin
                  m_tag[f][k] = int'(alloc_src_tag[(s*NSRC+k)*TAG_W +: TAG_W]);
                  if (alloc_src_kind[(s*NSRC+k)*2 +: 2] != 2'd3) begin
                     m_rdy[f][k] = 1;
                     m_dat[f][k] = int'(alloc_src_data[(s*NSRC+k)*DATA_W +: DATA_W]);
                  end else begin
                     m_rdy[f][k] = 0;
                     m_dat[f][k] = 0;
                     for (int c = 0; c < NBC; c++)
                        if (bc_valid[c] && int'(bc_tag[c*TAG_W +: TAG_W]) == m_tag[f][k]) begin
                           m_rdy[f][k] = 1;
                           m_dat[f][k] = int'(bc_data[c*DATA_W +: DATA_W]);
                        end
                  end
               end
            end
         end
      end
   endtask

   task automatic step();
      #1;
      compare();
      @(posedge clk);
      update();
      @(negedge clk);
      clear_in();
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nchk++; nfail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end

   initial begin
      clear_in();
      for (int e = 0; e < ENTRIES; e++) m_v[e] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: empty after reset, a full offer is taken
      alloc_valid = 3'b111;
      #1;
      chk(alloc_ready == 1'b1, "R1", alloc_ready, 1);
      chk(disp_valid == 3'b000, "R1", disp_valid, 0);
      alloc_valid = '0;
      idle(1);

      // R2 / R5: known-origin operands, one op per unit type
      cur_req = "R2 R5";
      put(0, 0, 1, 0, 0, 16'h1111, 1, 0, 16'h2222);
      put(1, 1, 2, 2, 0, 16'h3333, 0, 0, 16'h4444);
      put(2, 2, 3, 1, 0, 16'h5555, 2, 0, 16'h6666);
      idle(3);

      // R3: pending operand woken by a later broadcast
      cur_req = "R3";
      put(0, 0, 4, 0, 0, 16'h0007, 3, 5, 0);
      idle(2);
      bcast(1, 5, 16'hbeef);
      idle(3);

      // R4: bypass capture in the allocation cycle
      cur_req = "R4";
      put(0, 1, 6, 3, 7, 0, 3, 8, 0);
      bcast(0, 7, 16'h0a0a);
      bcast(1, 8, 16'h0b0b);
      idle(3);

      // R6: same-cycle ready ops contend for one port
      cur_req = "R6";
      put(0, 0, 10, 0, 0, 16'h000a, 0, 0, 16'h0001);
      put(1, 0, 11, 0, 0, 16'h000b, 0, 0, 16'h0002);
      put(2, 0, 12, 0, 0, 16'h000c, 0, 0, 16'h0003);
      idle(5);
      // R6: age across cycles, both woken together
      put(0, 2, 13, 3, 10, 0, 0, 0, 16'h0100);
      step();
      put(0, 2, 14, 3, 11, 0, 0, 0, 16'h0200);
      step();
      bcast(0, 11, 16'h1b1b);
      bcast(1, 10, 16'h1a1a);
      idle(4);

      // R8: younger ready op passes older waiting op
      cur_req = "R8";
      put(0, 0, 15, 3, 9, 0, 0, 0, 16'h0f0f);
      step();
      put(0, 0, 16, 0, 0, 16'h1616, 1, 0, 16'h6161);
      idle(2);
      bcast(0, 9, 16'h0909);
      idle(3);

      // R7: busy port holds its ready entry
      cur_req = "R7";
      put(0, 1, 17, 0, 0, 16'h1717, 0, 0, 16'h7171);
      step();
      for (int i = 0; i < 3; i++) begin
         port_busy = 3'b010;
         step();
      end
      idle(2);

      // R9 / R12: fill with ops that cannot wake
      cur_req = "R9 R12";
      for (int i = 0; i < 6; i++) begin
         for (int s = 0; s < 3; s++) put(s, s % 3, 20 + i*3 + s, 3, 60, 0, 0, 0, i*3 + s);
         step();
      end
      for (int s = 0; s < 3; s++) put(s, 0, 40 + s, 3, 60, 0, 0, 0, 16'h0040 + s);
      #1;
      chk(alloc_ready == 1'b0, "R9", alloc_ready, 0);
      step();
      put(0, 0, 43, 3, 60, 0, 0, 0, 16'h0043);
      put(2, 1, 44, 3, 60, 0, 0, 0, 16'h0044);
      #1;
      chk(alloc_ready == 1'b1, "R9", alloc_ready, 1);
      step();
      put(1, 2, 45, 0, 0, 16'h0045, 0, 0, 0);
      #1;
      chk(alloc_ready == 1'b0, "R12", alloc_ready, 0);
      step();
      cur_req = "R11";
      bcast(0, 60, 16'h6060);
      idle(12);

      // R10: flush over a ready entry and a pending offer
      cur_req = "R10";
      put(0, 0, 50, 3, 20, 0, 0, 0, 1);
      put(1, 1, 51, 3, 21, 0, 0, 0, 2);
      put(2, 2, 52, 0, 0, 16'h5252, 0, 0, 3);
      step();
      flush = 1'b1;
      put(0, 0, 53, 0, 0, 16'h5353, 0, 0, 4);
      #1;
      chk(disp_valid == 3'b000, "R10", disp_valid, 0);
      step();
      bcast(0, 20, 16'h2020);
      bcast(1, 21, 16'h2121);
      idle(3);
      chk(disp_valid == 3'b000, "R10", disp_valid, 0);

      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end
endmodule